// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home side of an invalidation-based directory protocol for a small group of processors. It also contains the tracker a writing processor uses to finish its write. Each line that this node is home to has a directory entry with one presence bit per processor and a dirty flag. The node also stores the line's data word in a local array.

A read of a clean line is answered from that array, and no other processor is involved. A read of a dirty line first recalls the data from the owning processor and stores it in home memory. The node then clears the dirty flag and answers the reader. A write returns the current sharer set to the writer, and the writer becomes the only holder with the line marked dirty. The writer's tracker sends one invalidate to each sharer and reports completion once every sharer has acknowledged.

The home of a line is given by its low address bits. A request for a line homed elsewhere is refused with a negative response. All channels use valid/ready handshakes. The node works on one transaction at a time.

Top module: `dir_home_node`

## Requirements
- R1: A request whose address bits [1:0] differ from NODE_ID (default 1) gets a response of kind 2 (refused) with data and sharer fields zero, and no recall is issued.
- R2: A read of a clean home line gets a response of kind 0 carrying the stored word, with no recall. After reset, the word of local index i (address bits [4:2]) is 0xA000+i.
- R3: The requester's presence bit is set when its read is accepted, so a later write by another processor lists it as a sharer.
- R4: A write gets a response of kind 1 whose sharer field (bit i = processor i) holds every present processor except the writer, and data zero.
- R5: After a write grant the entry holds only the writer and is dirty. A later read by another processor therefore recalls from the writer, and a later write lists only the previous writer.
- R6: A read of a dirty line issues a recall to the owner with the line address. The returned word is stored in home memory and sent to the reader. The dirty flag is then clear, so the next read needs no recall.
- R7: A write to a dirty line also recalls and stores the owner's data before granting, and the old owner appears in the sharer set.
- R8: req_ready is low from the cycle after a request is accepted until its response has been taken.
- R9: Response, recall and invalidate outputs stay valid and unchanged while their ready input is low.
- R10: The tracker sends exactly one invalidate per sharer in its loaded set, lowest processor index first.
- R11: The tracker's wr_done is high in the cycle after the last pending acknowledgement and for one cycle only. An empty set completes right after loading. A set of all other processors gives NPROC-1 invalidates.
- R12: An acknowledgement from a processor not pending in the set raises ack_err the next cycle and is not counted toward completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write (ownership), 0 = read |
| req_src | input | 2 | Requesting processor |
| req_addr | input | 5 | Line address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_dst | output | 2 | Processor the response goes to |
| rsp_kind | output | 2 | 0 data, 1 write grant, 2 refused |
| rsp_data | output | 16 | Line word for kind 0, else zero |
| rsp_sharers | output | 4 | Sharers to invalidate for kind 1 |
| rcl_valid | output | 1 | Recall to owner valid |
| rcl_ready | input | 1 | Recall taken |
| rcl_dst | output | 2 | Owner being recalled |
| rcl_addr | output | 5 | Line being recalled |
| wb_valid | input | 1 | Owner data returning |
| wb_ready | output | 1 | Home waiting for owner data |
| wb_data | input | 16 | Owner's line word |
| trk_load | input | 1 | Load a sharer set into the tracker (when idle) |
| trk_sharers | input | 4 | Sharer set to invalidate |
| trk_busy | output | 1 | Tracker holds an unfinished write |
| inv_valid | output | 1 | Invalidate valid |
| inv_ready | input | 1 | Invalidate taken |
| inv_dst | output | 2 | Processor to invalidate |
| ack_valid | input | 1 | Invalidate acknowledgement |
| ack_src | input | 2 | Acknowledging processor |
| wr_done | output | 1 | Write complete pulse |
| ack_err | output | 1 | Unexpected acknowledgement pulse |

## Verification
The directory is first driven with a sequence on one line: reads by two processors, then a write, then a read. This shows that presence bits accumulate, that a grant lists every sharer except the writer, and that a read after a write must recall rather than answer from memory. A second read after the recall separates "dirty cleared after write-back" from "dirty left set". A later write by a new processor on the same line separates a recall-then-grant path from a plain grant. Four readers followed by one writer on a fresh line give the all-others sharer set. The tracker is given a three-sharer set with a stray acknowledgement mixed in, and separately an empty set. These cases tell apart in-order issue, counting that refuses bad acknowledgements, and immediate completion.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;
  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_GRANT = 2'd1,
    RSP_NACK  = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECALL = 2'd1,
    ST_WB     = 2'd2,
    ST_RESP   = 2'd3
  } home_st_e;
endpackage

// File: rtl/dir_table.sv
module dir_table #(
  parameter int NLINE     = 8,
  parameter int NPROC     = 4,
  parameter int DATA_W    = 16,
  parameter int INIT_BASE = 16'hA000,
  localparam int IDX_W    = $clog2(NLINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic [NPROC-1:0]  pres_o,
  output logic              dirty_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              dir_we,
  input  logic [NPROC-1:0]  pres_i,
  input  logic              dirty_i,
  input  logic              mem_we,
  input  logic [DATA_W-1:0] data_i
);
  logic [NPROC-1:0]  pres_q  [NLINE];
  logic              dirty_q [NLINE];
  logic [DATA_W-1:0] mem_q   [NLINE];

  assign pres_o  = pres_q[idx];
  assign dirty_o = dirty_q[idx];
  assign data_o  = mem_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINE; i++) begin
        pres_q[i]  <= '0;
        dirty_q[i] <= 1'b0;
        mem_q[i]   <= DATA_W'(INIT_BASE + i);
      end
    end else begin
      for (int i = 0; i < NLINE; i++) begin
        if (dir_we && idx == IDX_W'(i)) begin
          pres_q[i]  <= pres_i;
          dirty_q[i] <= dirty_i;
        end
        if (mem_we && idx == IDX_W'(i)) begin
          mem_q[i] <= data_i;
        end
      end
    end
  end
endmodule

// File: rtl/inv_tracker.sv
module inv_tracker #(
  parameter int NPROC = 4,
  localparam int PW   = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trk_load,
  input  logic [NPROC-1:0] trk_sharers,
  output logic             trk_busy,
  output logic             inv_valid,
  input  logic             inv_ready,
  output logic [PW-1:0]    inv_dst,
  input  logic             ack_valid,
  input  logic [PW-1:0]    ack_src,
  output logic             wr_done,
  output logic             ack_err
);
  logic             busy_q, busy_n;
  logic [NPROC-1:0] send_q, send_n;
  logic [NPROC-1:0] pend_q, pend_n;
  logic             err_q, err_n;
  logic [NPROC-1:0] ack_bit;

  // lowest pending index goes out first
  always_comb begin
    inv_dst = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (send_q[i]) inv_dst = PW'(i);
    end
  end

  assign inv_valid = busy_q && (|send_q);
  assign wr_done   = busy_q && ~|send_q && ~|pend_q;
  assign trk_busy  = busy_q;
  assign ack_err   = err_q;
  assign ack_bit   = NPROC'(1) << ack_src;

  always_comb begin
    busy_n = busy_q;
    send_n = send_q;
    pend_n = pend_q;
    err_n  = 1'b0;
    if (!busy_q) begin
      if (trk_load) begin
        busy_n = 1'b1;
        send_n = trk_sharers;
        pend_n = trk_sharers;
      end
      err_n = ack_valid;
    end else begin
      if (inv_valid && inv_ready) send_n[inv_dst] = 1'b0;
      if (ack_valid) begin
        if ((pend_q & ack_bit) != '0) pend_n = pend_q & ~ack_bit;
        else                          err_n  = 1'b1;
      end
      if (wr_done) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      send_q <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      send_q <= send_n;
      pend_q <= pend_n;
      err_q  <= err_n;
    end
  end

  assert_inv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !inv_ready |=> inv_valid && $stable(inv_dst));
  assert_done_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && ack_valid && (pend_q & ack_bit) == '0 |=> ack_err);
endmodule

// File: rtl/dir_home_node.sv
module dir_home_node
  import dirhome_pkg::*;
#(
  parameter int NPROC     = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int NODE_ID   = 1,
  parameter int INIT_BASE = 16'hA000,
  localparam int PW       = $clog2(NPROC),
  localparam int IDX_W    = ADDR_W - PW,
  localparam int NLINE    = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PW-1:0]     req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PW-1:0]     rsp_dst,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic [NPROC-1:0]  rsp_sharers,
  output logic              rcl_valid,
  input  logic              rcl_ready,
  output logic [PW-1:0]     rcl_dst,
  output logic [ADDR_W-1:0] rcl_addr,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              trk_load,
  input  logic [NPROC-1:0]  trk_sharers,
  output logic              trk_busy,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [PW-1:0]     inv_dst,
  input  logic              ack_valid,
  input  logic [PW-1:0]     ack_src,
  output logic              wr_done,
  output logic              ack_err
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  home_st_e          st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [PW-1:0]     src_q, src_n, own_q, own_n;
  logic              wr_q, wr_n;
  rsp_kind_e         kind_q, kind_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [NPROC-1:0]  sh_q, sh_n;

  logic [IDX_W-1:0]  idx;
  logic [NPROC-1:0]  pres_o, pres_i, src_bit;
  logic              dirty_o, dirty_i, dir_we, mem_we;
  logic [DATA_W-1:0] data_o;
  logic [PW-1:0]     owner;
  logic              accept, is_home;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign is_home   = (req_addr[PW-1:0] == PW'(NODE_ID));
  assign idx       = (st_q == ST_IDLE) ? req_addr[ADDR_W-1:PW] : addr_q[ADDR_W-1:PW];
  assign src_bit   = NPROC'(1) << req_src;

  always_comb begin
    owner = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (pres_o[i]) owner = PW'(i);
    end
  end

  dir_table #(
    .NLINE(NLINE), .NPROC(NPROC), .DATA_W(DATA_W), .INIT_BASE(INIT_BASE)
  ) i_table (
    .clk(clk), .rst_n(rst_i_n), .idx(idx),
    .pres_o(pres_o), .dirty_o(dirty_o), .data_o(data_o),
    .dir_we(dir_we), .pres_i(pres_i), .dirty_i(dirty_i),
    .mem_we(mem_we), .data_i(wb_data)
  );

  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    src_n   = src_q;
    own_n   = own_q;
    wr_n    = wr_q;
    kind_n  = kind_q;
    data_n  = data_q;
    sh_n    = sh_q;
    dir_we  = 1'b0;
    pres_i  = pres_o;
    dirty_i = dirty_o;
    mem_we  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        addr_n = req_addr;
        src_n  = req_src;
        wr_n   = req_write;
        data_n = '0;
        sh_n   = '0;
        st_n   = ST_RESP;
        if (!is_home) begin
          kind_n = RSP_NACK;
        end else begin
          kind_n = req_write ? RSP_GRANT : RSP_DATA;
          own_n  = owner;
          dir_we = 1'b1;
          if (req_write) begin
            sh_n    = pres_o & ~src_bit;
            pres_i  = src_bit;
            dirty_i = 1'b1;
          end else begin
            pres_i = pres_o | src_bit;
          end
          if (dirty_o)        st_n   = ST_RECALL;
          else if (!req_write) data_n = data_o;
        end
      end
      ST_RECALL: if (rcl_ready) st_n = ST_WB;
      ST_WB: if (wb_valid) begin
        mem_we = 1'b1;
        st_n   = ST_RESP;
        if (!wr_q) begin
          dir_we  = 1'b1;
          dirty_i = 1'b0;
          data_n  = wb_data;
        end
      end
      ST_RESP: if (rsp_ready) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      src_q  <= '0;
      own_q  <= '0;
      wr_q   <= 1'b0;
      kind_q <= RSP_DATA;
      data_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      src_q  <= src_n;
      own_q  <= own_n;
      wr_q   <= wr_n;
      kind_q <= kind_n;
      data_q <= data_n;
      sh_q   <= sh_n;
    end
  end

  assign rsp_valid   = (st_q == ST_RESP);
  assign rsp_dst     = src_q;
  assign rsp_kind    = kind_q;
  assign rsp_data    = data_q;
  assign rsp_sharers = sh_q;
  assign rcl_valid   = (st_q == ST_RECALL);
  assign rcl_dst     = own_q;
  assign rcl_addr    = addr_q;
  assign wb_ready    = (st_q == ST_WB);

  inv_tracker #(.NPROC(NPROC)) i_trk (
    .clk(clk), .rst_n(rst_i_n),
    .trk_load(trk_load), .trk_sharers(trk_sharers), .trk_busy(trk_busy),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_dst(inv_dst),
    .ack_valid(ack_valid), .ack_src(ack_src),
    .wr_done(wr_done), .ack_err(ack_err)
  );

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    accept |=> !req_ready);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
                               && $stable(rsp_sharers) && $stable(rsp_kind));
  assert_rcl_hold_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    rcl_valid && !rcl_ready |=> rcl_valid && $stable(rcl_dst) && $stable(rcl_addr));
  assert_grant_excl_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid && rsp_kind == 2'd1 |-> !rsp_sharers[rsp_dst]);
  assert_grant_owner_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid && rsp_kind == 2'd1 |-> dirty_o && pres_o == (NPROC'(1) << src_q));
  assert_wb_clean_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    wb_valid && wb_ready && !wr_q |=> !dirty_o && rsp_data == $past(wb_data));
endmodule

// File: tb/test_dir_home_node.sv
module test_dir_home_node;
  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [1:0] req_src;
  logic [4:0] req_addr;
  logic rsp_valid, rsp_ready;
  logic [1:0] rsp_dst, rsp_kind;
  logic [15:0] rsp_data;
  logic [3:0] rsp_sharers;
  logic rcl_valid, rcl_ready;
  logic [1:0] rcl_dst;
  logic [4:0] rcl_addr;
  logic wb_valid, wb_ready;
  logic [15:0] wb_data;
  logic trk_load, trk_busy, inv_valid, inv_ready, ack_valid, wr_done, ack_err;
  logic [3:0] trk_sharers;
  logic [1:0] inv_dst, ack_src;

  int total = 0;
  int bad = 0;

  dir_home_node i_dir_home_node (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // wr src addr kind rcl rdst val wb
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 2'd0, 5'd1,  2'd0, 1'b0, 2'd0, 16'hA000, 16'h0000},
    {1'b0, 2'd2, 5'd1,  2'd0, 1'b0, 2'd0, 16'hA000, 16'h0000},
    {1'b1, 2'd3, 5'd1,  2'd1, 1'b0, 2'd0, 16'h0005, 16'h0000},
    {1'b0, 2'd0, 5'd1,  2'd0, 1'b1, 2'd3, 16'h1234, 16'h1234},
    {1'b0, 2'd1, 5'd1,  2'd0, 1'b0, 2'd0, 16'h1234, 16'h0000},
    {1'b1, 2'd1, 5'd1,  2'd1, 1'b0, 2'd0, 16'h0009, 16'h0000},
    {1'b1, 2'd2, 5'd1,  2'd1, 1'b1, 2'd1, 16'h0002, 16'hBEEF},
    {1'b0, 2'd0, 5'd2,  2'd2, 1'b0, 2'd0, 16'h0000, 16'h0000},
    {1'b0, 2'd0, 5'd5,  2'd0, 1'b0, 2'd0, 16'hA001, 16'h0000},
    {1'b1, 2'd3, 5'd5,  2'd1, 1'b0, 2'd0, 16'h0001, 16'h0000},
    {1'b0, 2'd1, 5'd9,  2'd0, 1'b0, 2'd0, 16'hA002, 16'h0000},
    {1'b0, 2'd3, 5'd1,  2'd0, 1'b1, 2'd2, 16'h5555, 16'h5555},
    {1'b0, 2'd0, 5'd1,  2'd0, 1'b0, 2'd0, 16'h5555, 16'h0000},
    {1'b0, 2'd0, 5'd13, 2'd0, 1'b0, 2'd0, 16'hA003, 16'h0000},
    {1'b0, 2'd1, 5'd13, 2'd0, 1'b0, 2'd0, 16'hA003, 16'h0000},
    {1'b0, 2'd2, 5'd13, 2'd0, 1'b0, 2'd0, 16'hA003, 16'h0000},
    {1'b0, 2'd3, 5'd13, 2'd0, 1'b0, 2'd0, 16'hA003, 16'h0000},
    {1'b1, 2'd0, 5'd13, 2'd1, 1'b0, 2'd0, 16'h000E, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [1:0] src, input logic [4:0] addr,
                        input logic [15:0] wbd, input int hold,
                        output logic [1:0] kind, output logic [15:0] val,
                        output bit rseen, output logic [1:0] rdst);
    rseen = 1'b0; rdst = '0; kind = '0; val = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_src = src; req_addr = addr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 40; n++) begin
      if (rcl_valid) begin
        rseen = 1'b1; rdst = rcl_dst;
        chk(rcl_addr == addr, "R6 recall address", rcl_addr, addr);
        chk(!req_ready, "R8 ready low during recall", req_ready, 0);
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk(rcl_valid && rcl_dst == rdst, "R9 recall held", rcl_dst, rdst);
        end
        rcl_ready = 1'b1;
        @(negedge clk);
        rcl_ready = 1'b0;
        wb_valid = 1'b1; wb_data = wbd;
        while (!wb_ready) @(negedge clk);
        @(negedge clk);
        wb_valid = 1'b0;
      end
      if (rsp_valid) begin
        kind = rsp_kind;
        val  = (rsp_kind == 2'd1) ? {12'd0, rsp_sharers} : rsp_data;
        chk(rsp_dst == src, "R2 response destination", rsp_dst, src);
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk(rsp_valid && rsp_kind == kind && !req_ready, "R9 R8 response held",
              rsp_kind, kind);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] k, rd;
    logic [15:0] v;
    bit rs;
    logic [1:0] seen [$];
    req_valid = 0; req_write = 0; req_src = 0; req_addr = 0;
    rsp_ready = 0; rcl_ready = 0; wb_valid = 0; wb_data = 0;
    trk_load = 0; trk_sharers = 0; inv_ready = 0; ack_valid = 0; ack_src = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !rcl_valid && !inv_valid && !wr_done && !trk_busy,
        "reset state R8", {req_ready, rsp_valid, rcl_valid}, 3'b100);

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][44], VEC[i][43:42], VEC[i][41:37], VEC[i][15:0], 0, k, v, rs, rd);
      chk(k == VEC[i][36:35], $sformatf("R1 R2 R4 kind vec%0d", i), k, VEC[i][36:35]);
      chk(v == VEC[i][31:16], $sformatf("R3 R5 R6 R7 value vec%0d", i), v, VEC[i][31:16]);
      chk(rs == VEC[i][34] && (!rs || rd == VEC[i][33:32]),
          $sformatf("R5 R6 recall vec%0d", i), {rs, rd}, VEC[i][34:32]);
    end

    // R9 / R8: held handshakes on a dirty line (addr 5 owned by P3)
    do_req(1'b0, 2'd1, 5'd5, 16'h7777, 2, k, v, rs, rd);
    chk(rs && rd == 2'd3, "R6 recall to writer", rd, 3);
    chk(k == 2'd0 && v == 16'h7777, "R6 written-back data", v, 16'h7777);

    // tracker: R10 R11 R12
    @(negedge clk);
    trk_load = 1'b1; trk_sharers = 4'b1110;
    @(negedge clk);
    trk_load = 1'b0;
    inv_ready = 1'b1;
    for (int n = 0; n < 10; n++) begin
      if (inv_valid) seen.push_back(inv_dst);
      @(negedge clk);
    end
    inv_ready = 1'b0;
    chk(seen.size() == 3, "R11 invalidate count P-1", seen.size(), 3);
    if (seen.size() == 3)
      chk(seen[0] == 1 && seen[1] == 2 && seen[2] == 3, "R10 invalidate order",
          {seen[0], seen[1], seen[2]}, 6'b011011);
    ack_valid = 1'b1; ack_src = 2'd0;
    @(posedge clk); #1;
    chk(ack_err == 1'b1, "R12 stray ack flagged", ack_err, 1);
    @(negedge clk);
    for (int a = 1; a <= 3; a++) begin
      ack_src = 2'(a);
      @(posedge clk); #1;
      chk(ack_err == 1'b0, "R12 valid ack not flagged", ack_err, 0);
      chk(wr_done == (a == 3), "R11 R12 done after last ack", wr_done, a == 3);
      @(negedge clk);
    end
    ack_valid = 1'b0;
    @(posedge clk); #1;
    chk(!wr_done && !trk_busy, "R11 done single cycle", wr_done, 0);

    @(negedge clk);
    trk_load = 1'b1; trk_sharers = 4'b0000;
    @(posedge clk); #1;
    chk(wr_done && !inv_valid, "R11 empty set completes", wr_done, 1);
    @(negedge clk);
    trk_load = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule